// File: doc/BRIEF.md
# System clock divider chain

This block runs on one fast root clock and produces three clock-enable strobes: one for the CPU domain, one for the high-speed bus and one for the peripheral bus. Logic in each domain stays on the root clock and advances only on cycles where its strobe is high. One 32-bit control word, written through a single-cycle write port, selects how often each strobe fires.

The CPU and bus divisors each come from a 5-bit field with its own enable bit. A clear enable gives a divisor of 1. A set enable gives a divisor of twice the field plus one, so only 1 and even divisors can be reached. The peripheral strobe is derived from the bus strobe: it fires on every N-th bus strobe, where N is a 6-bit ratio field plus one. As a result it always coincides with a bus strobe. The control word also holds a peripheral divider field with its own enable bit. That field is stored and read back only. Software keeps it consistent with bus divisor times ratio, but the block does not use it for timing.

A write does not take effect at once. It is parked as pending and a busy flag rises. The setting is applied on the first cycle on which the CPU strobe and the peripheral strobe fire together. At that point every counter is at its terminal count, so no strobe period is cut short. Readback always shows the setting in force. Software can therefore either poll it until it equals the written value or wait for busy to drop.

Top module: `sclk_div_chain`

## Requirements
- R1: After reset, readback is 0, busy is low, and all three strobes are high on every cycle (divisor 1, ratio 1).
- R2: The CPU divisor is 1 when bit 30 is 0, and 2*(F+1) when bit 30 is 1, where F is bits 28:24. With divisor D, the CPU strobe is high on cycles D-1, 2D-1, ... counted from the first cycle after an apply.
- R3: The bus divisor is 1 when bit 22 is 0, and 2*(F+1) when bit 22 is 1, where F is bits 20:16. It has the same strobe timing as R2.
- R4: With ratio field bits 5:0 = Q, the peripheral strobe is high on every (Q+1)-th bus strobe. It is never high without the bus strobe, so its period is the bus divisor times (Q+1).
- R5: Readback shows the applied setting, masked to the defined bits (mask 0x5F5F5F3F), so reserved bits read 0. A pending value is never visible on readback.
- R6: Busy is high from the cycle after a write until the cycle after that write is applied.
- R7: A pending setting is applied only at the end of a cycle in which the CPU and peripheral strobes are both high and no write is presented. All counters restart from zero at that point.
- R8: A write made while busy replaces the pending value, and the last value written is the one applied.
- R9: The peripheral divider field (enable bit 14, field bits 12:8) is stored and read back but has no effect on any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Applied control word, masked |
| cfg_busy | output | 1 | A written setting is waiting to be applied |
| cpu_ce | output | 1 | CPU domain clock enable |
| bus_ce | output | 1 | High-speed bus clock enable |
| per_ce | output | 1 | Peripheral bus clock enable |

## Verification
The bench checks strobe patterns cycle by cycle after each apply, so two kinds of fault show up as a misplaced strobe: a divisor decoded as F+1 rather than 2*(F+1), and a set enable bit that is ignored. It times the busy window for a write made in the middle of a period. That window is exactly 18 cycles long, and a design that applies early would show a shortened strobe period and a shorter busy window. It writes all ones to catch reserved bits leaking into readback, and sets a non-zero field with its enable clear to catch a design that honours that field anyway. Back-to-back writes while busy catch a design that applies the first value instead of the last.

// File: rtl/sclk_pkg.sv
// Shared field layout and helpers for the system clock divider chain.
// Assumes a 32-bit control word; positions are fixed because software decodes them.
package sclk_pkg;
    localparam int WORD_W  = 32;
    localparam int DIV_W   = 5;
    localparam int RAT_W   = 6;
    localparam int CNT_W   = DIV_W + 1;
    localparam int STAGES  = 2;
    localparam int CPU_LSB = 24;
    localparam int CPU_EN  = 30;
    localparam int BUS_LSB = 16;
    localparam int BUS_EN  = 22;
    localparam int PER_LSB = 8;
    localparam int PER_EN  = 14;
    localparam int RAT_LSB = 0;

    localparam logic [WORD_W-1:0] CFG_MASK =
          (WORD_W'(1) << CPU_EN) | (WORD_W'((1 << DIV_W) - 1) << CPU_LSB)
        | (WORD_W'(1) << BUS_EN) | (WORD_W'((1 << DIV_W) - 1) << BUS_LSB)
        | (WORD_W'(1) << PER_EN) | (WORD_W'((1 << DIV_W) - 1) << PER_LSB)
        | (WORD_W'((1 << RAT_W) - 1) << RAT_LSB);

    // Terminal count (divisor minus one) for an enable/field pair.
    function automatic logic [CNT_W-1:0] div_limit(input logic en,
                                                   input logic [DIV_W-1:0] fld);
        return en ? {fld, 1'b1} : '0;
    endfunction
endpackage

// File: rtl/sclk_cfg_reg.sv
// Control word holder: pending copy, applied copy and busy flag.
// Assumes 'align' marks a cycle where every strobe counter is at terminal count.
module sclk_cfg_reg
    import sclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              align,
    output logic [WORD_W-1:0] applied,
    output logic              busy,
    output logic              apply
);
    logic [WORD_W-1:0] pend_q;
    logic [WORD_W-1:0] cur_q;
    logic              busy_q;

    // Apply when a setting waits, nothing new arrives, and all counters wrap.
    assign apply = busy_q & ~wr_en & align;

    // Capture writes as pending; promote pending to applied at alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            cur_q  <= '0;
            busy_q <= 1'b0;
        end else if (wr_en) begin
            pend_q <= wr_data & CFG_MASK;
            busy_q <= 1'b1;
        end else if (apply) begin
            cur_q  <= pend_q;
            busy_q <= 1'b0;
        end
    end

    assign applied = cur_q;
    assign busy    = busy_q;

    // R6
    wr_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy_q);
    // R5
    hold_until_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> $fell(busy_q));
    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q & ~CFG_MASK) == '0);
endmodule

// File: rtl/sclk_field_decode.sv
// Turns the applied enable/field pairs into counter terminal values.
// Assumes fields arrive already sliced from the applied control word.
module sclk_field_decode
    import sclk_pkg::*;
(
    input  logic             cpu_en,
    input  logic [DIV_W-1:0] cpu_fld,
    input  logic             bus_en,
    input  logic [DIV_W-1:0] bus_fld,
    input  logic [RAT_W-1:0] rat_fld,
    output logic [CNT_W-1:0] cpu_lim,
    output logic [CNT_W-1:0] bus_lim,
    output logic [RAT_W-1:0] rat_lim
);
    // Divisor 1 when disabled, 2*(field+1) when enabled; ratio is field+1.
    always_comb begin
        cpu_lim = div_limit(cpu_en, cpu_fld);
        bus_lim = div_limit(bus_en, bus_fld);
        rat_lim = rat_fld;
    end
endmodule

// File: rtl/sclk_stage_cnt.sv
// Wrapping counter that emits a strobe on its terminal count.
// Assumes 'lim' only changes together with 'restart'.
module sclk_stage_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         restart,
    input  logic [W-1:0] lim,
    output logic         stb
);
    logic [W-1:0] cnt_q;
    logic         tc;

    // Terminal count reached in this cycle.
    assign tc  = (cnt_q == lim);
    assign stb = adv & tc;

    // Count advancing cycles, wrap at terminal, restart on apply.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= tc ? '0 : cnt_q + 1'b1;
    end

    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);
endmodule

// File: rtl/sclk_div_chain.sv
// Top of the divider chain: control word, decode, CPU/bus counters and
// the ratio counter that derives the peripheral strobe from the bus strobe.
// Assumes all consumers run on clk and qualify with their strobe.
module sclk_div_chain
    import sclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    output logic              cfg_busy,
    output logic              cpu_ce,
    output logic              bus_ce,
    output logic              per_ce
);
    logic [WORD_W-1:0] cur_cfg;
    logic              apply;
    logic              align;
    logic [CNT_W-1:0]  lim [STAGES];
    logic [STAGES-1:0] stg_stb;
    logic [RAT_W-1:0]  rat_lim;
    logic              rat_stb;

    sclk_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .align   (align),
        .applied (cur_cfg),
        .busy    (cfg_busy),
        .apply   (apply)
    );

    sclk_field_decode u_dec (
        .cpu_en  (cur_cfg[CPU_EN]),
        .cpu_fld (cur_cfg[CPU_LSB +: DIV_W]),
        .bus_en  (cur_cfg[BUS_EN]),
        .bus_fld (cur_cfg[BUS_LSB +: DIV_W]),
        .rat_fld (cur_cfg[RAT_LSB +: RAT_W]),
        .cpu_lim (lim[0]),
        .bus_lim (lim[1]),
        .rat_lim (rat_lim)
    );

    // One free-running divider per root-derived domain (CPU, bus).
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        sclk_stage_cnt #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (1'b1),
            .restart (apply),
            .lim     (lim[g]),
            .stb     (stg_stb[g])
        );
    end

    // Peripheral strobe: count bus strobes, so it always lands on one.
    sclk_stage_cnt #(.W(RAT_W)) u_rat (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (stg_stb[1]),
        .restart (apply),
        .lim     (rat_lim),
        .stb     (rat_stb)
    );

    // Drive outputs and the alignment point for applying new settings.
    always_comb begin
        cpu_ce    = stg_stb[0];
        bus_ce    = stg_stb[1];
        per_ce    = rat_stb;
        align     = cpu_ce & per_ce;
        cfg_rdata = cur_cfg;
    end

    // R4
    per_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ce |-> bus_ce);
    // R7
    apply_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_busy) |-> $past(cpu_ce && per_ce && !cfg_wr));
endmodule

// File: tb/sclk_div_chain_tb_top.sv
// Directed bench for the divider chain; one task per scenario.
module sclk_div_chain_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_busy, cpu_ce, bus_ce, per_ce;
    int          n_chk = 0;
    int          n_err = 0;

    always #5 clk = ~clk;

    sclk_div_chain dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_busy(cfg_busy),
        .cpu_ce(cpu_ce), .bus_ce(bus_ce), .per_ce(per_ce)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Returns at the first negedge with busy low (cycle 0 after apply).
    task automatic wait_apply(output int n);
        n = 0;
        while (cfg_busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (cfg_busy) check(1'b0, "R7 apply timeout", 1, 0);
    endtask

    // Compare strobes against the expected periods from cycle 0.
    task automatic check_pattern(input int dc, input int dh, input int r,
                                 input int ncyc, input string tag);
        int bad_c = 0, bad_b = 0, bad_p = 0;
        for (int i = 0; i < ncyc; i++) begin
            if (cpu_ce !== ((i % dc) == dc - 1)) bad_c++;
            if (bus_ce !== ((i % dh) == dh - 1)) bad_b++;
            if (per_ce !== ((i % (dh * r)) == dh * r - 1)) bad_p++;
            @(negedge clk);
        end
        check(bad_c == 0, {"R2 cpu pattern ", tag}, bad_c, 0);
        check(bad_b == 0, {"R3 bus pattern ", tag}, bad_b, 0);
        check(bad_p == 0, {"R4 per pattern ", tag}, bad_p, 0);
    endtask

    task automatic t_reset();
        check(cfg_rdata == 32'h0, "R1 reset rdata", cfg_rdata, 0);
        check(cfg_busy == 1'b0, "R1 reset busy", cfg_busy, 0);
        check({cpu_ce, bus_ce, per_ce} == 3'b111, "R1 reset strobes",
              {cpu_ce, bus_ce, per_ce}, 3'b111);
    endtask

    task automatic t_apply(input logic [31:0] v, input logic [31:0] exp_rd,
                           input int dc, input int dh, input int r, input string tag);
        int n;
        do_write(v);
        check(cfg_busy == 1'b1, {"R6 busy after write ", tag}, cfg_busy, 1);
        wait_apply(n);
        check(cfg_rdata == exp_rd, {"R5 readback ", tag}, cfg_rdata, exp_rd);
        check_pattern(dc, dh, r, 48, tag);
    endtask

    task automatic t_deferred();
        int n;
        logic [31:0] old;
        do_write(32'h4241_4301);
        wait_apply(n);
        old = cfg_rdata;
        repeat (4) @(negedge clk);
        do_write(32'h0000_0000);
        check(cfg_rdata == old, "R5 pending hidden", cfg_rdata, old);
        wait_apply(n);
        check(n == 18, "R7 deferred busy cycles", n, 18);
        check(cfg_rdata == 32'h0, "R7 applied after align", cfg_rdata, 0);
        check_pattern(1, 1, 1, 8, "deferred");
    endtask

    task automatic t_overwrite();
        int n;
        do_write(32'h4100_0000);
        do_write(32'h0040_0002);
        wait_apply(n);
        check(cfg_rdata == 32'h0040_0002, "R8 last write wins", cfg_rdata, 32'h0040_0002);
        check_pattern(1, 2, 3, 48, "overwrite");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_apply(32'h4100_0000, 32'h4100_0000, 4, 1, 1, "cpu4");
        t_apply(32'h0040_0002, 32'h0040_0002, 1, 2, 3, "bus2 ratio3");
        // R9: per field set, cpu field set without enable: no effect
        t_apply(32'h0500_4700, 32'h0500_4700, 1, 1, 1, "enable-off R9");
        t_apply(32'h4241_4301, 32'h4241_4301, 6, 4, 2, "mixed");
        t_deferred();
        t_apply(32'hFFFF_FFFF, 32'h5F5F_5F3F, 64, 64, 64, "all-ones");
        t_overwrite();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(10 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule